// File: doc/BRIEF.md
# Root Port Ownership Router

This block decides, for every root port of a dual-controller host, which of two controllers drives that port: the high-speed host controller or a companion controller that serves full- and low-speed devices. A single configure flag, written by the high-speed driver, enables the high-speed side. Each port supplies a connect status and a bit saying whether the attached device turned out to be high-speed. The connect status is taken to rise only after speed detection has finished, so the speed bit is valid whenever the port shows a connection.

When the flag is low, the companion owns every port. When the flag is high, the high-speed controller claims each port. It keeps a port whose device is high-speed and hands over a port whose device is not. A handover is shown to both controllers as one-cycle events: a disconnect toward the high-speed side and a connect toward the companion. When the device on a handed-over port leaves, the high-speed controller takes that port back. Each port has its own small state machine, and all outputs are registered.

Top module: `port_owner_router`

## Requirements
- R1: During and right after reset, every owner bit is 0 (companion owns) and no event pulse is high.
- R2: While the configure flag is 0, every owner bit reads 0 and no event pulse is raised, whatever the connect and speed inputs do.
- R3: A port owned by the companion because the flag was low reads owner bit 1 (high-speed controller owns) one clock after the flag is sampled high.
- R4: A high-speed-owned port with a connected high-speed device keeps owner bit 1 and raises no event.
- R5: A high-speed-owned port with a connected device whose speed bit is 0 shows owner bit 0 one clock later. In that same cycle it shows a single-cycle pulse on both its high-speed disconnect output and its companion connect output.
- R6: A handed-over port stays with the companion and raises no further event while its device stays connected.
- R7: A handed-over port whose connect input falls returns to owner bit 1 one clock later, with no event pulse.
- R8: Sampling the flag at 0 returns every port to the companion on the next clock, with no event, and this overrides any per-port state. A handover that was about to happen is dropped.
- R9: Ports are independent: an input change on one port alters no other port's owner bit or events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 1 | Configure flag from high-speed software |
| conn_i | input | NPORTS | Per-port connect status |
| hs_i | input | NPORTS | Per-port device-is-high-speed bit, valid while connected |
| own_hs_o | output | NPORTS | 1 = high-speed controller owns the port, 0 = companion |
| hs_disc_o | output | NPORTS | One-cycle disconnect event toward the high-speed controller |
| cmp_conn_o | output | NPORTS | One-cycle connect event toward the companion controller |

## Verification
Directed sequences cover a high-speed attach that stays put, a full-speed attach that is handed over and later reclaimed on detach, and flag toggles while ports are connected. Together they separate a correct handover from a missing, repeated or mis-ported pulse. Long runs of random traffic toggle connects per port with a random speed and flip the flag now and then. These runs expose cross-port coupling and mistakes in the order of the override, such as a handover pulse that escapes in the cycle the flag falls.

// File: rtl/port_route_pkg.sv
package port_route_pkg;

    typedef enum logic [1:0] {
        PS_COMP = 2'd0,   // companion owns, controller not configured
        PS_HOLD = 2'd1,   // high-speed controller owns
        PS_LENT = 2'd2    // handed to companion for a slower device
    } port_st_e;

    typedef struct packed {
        port_st_e st;
        logic     owner_hs;
        logic     hs_disc;
        logic     cmp_conn;
    } port_reg_t;

    localparam port_reg_t PORT_RESET = '{st: PS_COMP, owner_hs: 1'b0,
                                         hs_disc: 1'b0, cmp_conn: 1'b0};

endpackage

// File: rtl/port_route_fsm.sv
module port_route_fsm
    import port_route_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_i,
    input  logic conn_i,
    input  logic hs_i,
    output logic own_hs_o,
    output logic hs_disc_o,
    output logic cmp_conn_o
);

    port_reg_t r_d, r_q;

    always_comb begin
        r_d          = r_q;
        r_d.hs_disc  = 1'b0;
        r_d.cmp_conn = 1'b0;
        if (!cfg_i) begin
            // global override: companion owns, nothing announced
            r_d.st = PS_COMP;
        end else begin
            unique case (r_q.st)
                PS_COMP: r_d.st = PS_HOLD;
                PS_HOLD: begin
                    if (conn_i && !hs_i) begin
                        r_d.st       = PS_LENT;
                        r_d.hs_disc  = 1'b1;
                        r_d.cmp_conn = 1'b1;
                    end
                end
                PS_LENT: begin
                    if (!conn_i) r_d.st = PS_HOLD;
                end
                default: r_d.st = PS_COMP;
            endcase
        end
        r_d.owner_hs = (r_d.st == PS_HOLD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= PORT_RESET;
        else        r_q <= r_d;
    end

    assign own_hs_o   = r_q.owner_hs;
    assign hs_disc_o  = r_q.hs_disc;
    assign cmp_conn_o = r_q.cmp_conn;

endmodule

// File: rtl/port_owner_router.sv
module port_owner_router #(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_i,
    input  logic [NPORTS-1:0] conn_i,
    input  logic [NPORTS-1:0] hs_i,
    output logic [NPORTS-1:0] own_hs_o,
    output logic [NPORTS-1:0] hs_disc_o,
    output logic [NPORTS-1:0] cmp_conn_o
);

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        port_route_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_i     (cfg_i),
            .conn_i    (conn_i[p]),
            .hs_i      (hs_i[p]),
            .own_hs_o  (own_hs_o[p]),
            .hs_disc_o (hs_disc_o[p]),
            .cmp_conn_o(cmp_conn_o[p])
        );
    end

endmodule

// File: rtl/port_owner_router_chk.sv
module port_owner_router_chk #(
    parameter int NPORTS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_i,
    input logic [NPORTS-1:0] conn_i,
    input logic [NPORTS-1:0] hs_i,
    input logic [NPORTS-1:0] own_hs_o,
    input logic [NPORTS-1:0] hs_disc_o,
    input logic [NPORTS-1:0] cmp_conn_o
);

    AST_CFG_LOW_COMPANION: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i |=> (own_hs_o == '0) && (hs_disc_o == '0) && (cmp_conn_o == '0)); // R8

    AST_HS_DEVICE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i |=> (($past(own_hs_o & conn_i & hs_i) & ~own_hs_o) == '0)); // R4

    AST_IDLE_PORT_TO_HS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i |=> (($past(~own_hs_o & ~conn_i) & ~own_hs_o) == '0)); // R7

    AST_EVENT_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_disc_o != '0) |-> ((hs_disc_o & ~($past(own_hs_o) & ~own_hs_o)) == '0)); // R5

    AST_EVENT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_conn_o != '0) |=> ((cmp_conn_o & $past(cmp_conn_o)) == '0)); // R6

    AST_EVENT_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_disc_o != '0) |-> ($countones(hs_disc_o ^ cmp_conn_o) == 0)); // R5

endmodule

bind port_owner_router port_owner_router_chk #(.NPORTS(NPORTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_i     (cfg_i),
    .conn_i    (conn_i),
    .hs_i      (hs_i),
    .own_hs_o  (own_hs_o),
    .hs_disc_o (hs_disc_o),
    .cmp_conn_o(cmp_conn_o)
);

// File: tb/port_owner_router_bench.sv
module port_owner_router_bench;

    localparam int NP         = 4;
    localparam int CLK_PERIOD = 10;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg   = 1'b0;
    logic [NP-1:0] conn  = '0;
    logic [NP-1:0] hs    = '0;
    logic [NP-1:0] own_hs, hs_disc, cmp_conn;

    int m_st [NP];      // 0 companion idle, 1 high-speed owns, 2 handed over
    int vectors = 0;
    int fails   = 0;

    port_owner_router #(.NPORTS(NP)) u_port_owner_router (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .conn_i(conn), .hs_i(hs),
        .own_hs_o(own_hs), .hs_disc_o(hs_disc), .cmp_conn_o(cmp_conn)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int next_st(int st, logic c, logic cn, logic h, output logic ev);
        ev = 1'b0;
        if (!c) return 0;
        case (st)
            0: return 1;
            1: if (cn && !h) begin ev = 1'b1; return 2; end else return 1;
            default: return cn ? 2 : 1;
        endcase
    endfunction

    task automatic check_bit(string tag, int p, string what, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s port %0d %s: actual %0b expected %0b", tag, p, what, act, exp);
        end
    endtask

    // inputs are already set (just after a negedge); advance one clock and compare
    task automatic step(string tag);
        int   ns [NP];
        logic ev [NP];
        for (int p = 0; p < NP; p++) ns[p] = next_st(m_st[p], cfg, conn[p], hs[p], ev[p]);
        @(posedge clk); #1;
        for (int p = 0; p < NP; p++) begin
            check_bit(tag, p, "owner",    own_hs[p],   logic'(ns[p] == 1));
            check_bit(tag, p, "hs_disc",  hs_disc[p],  ev[p]);
            check_bit(tag, p, "cmp_conn", cmp_conn[p], ev[p]);
            m_st[p] = ns[p];
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240517));
        for (int p = 0; p < NP; p++) m_st[p] = 0;
        repeat (3) @(negedge clk);
        for (int p = 0; p < NP; p++) begin           // R1: reset state
            check_bit("R1", p, "owner",    own_hs[p],   1'b0);
            check_bit("R1", p, "hs_disc",  hs_disc[p],  1'b0);
            check_bit("R1", p, "cmp_conn", cmp_conn[p], 1'b0);
        end
        rst_n = 1'b1;
        step("R1");
        // R2: flag low, inputs ignored
        conn = 4'b1011; hs = 4'b0010; step("R2");
        conn = 4'b0101; hs = 4'b0000; step("R2");
        // R3: configure with empty ports
        conn = '0; hs = '0; cfg = 1'b1; step("R3");
        // R4: high-speed attach on port 0 stays
        conn[0] = 1'b1; hs[0] = 1'b1; step("R4"); step("R4");
        // R5: full-speed attach on port 1 handed over
        conn[1] = 1'b1; hs[1] = 1'b0; step("R5");
        // R6: stays with companion, no repeat pulse
        step("R6"); step("R6");
        // R7: detach returns port 1
        conn[1] = 1'b0; step("R7"); step("R7");
        // R8: flag drop during connected ports and a pending handover
        conn[2] = 1'b1; hs[2] = 1'b0; step("R5");
        conn[3] = 1'b1; hs[3] = 1'b0; cfg = 1'b0; step("R8"); step("R8");
        // R3 then R5: reconfigure with devices attached
        cfg = 1'b1; step("R3"); step("R5"); step("R6");
        // R9: random traffic
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 40 == 0) cfg = ~cfg;
            for (int p = 0; p < NP; p++) begin
                if ($urandom % 8 == 0) begin
                    conn[p] = ~conn[p];
                    if (conn[p]) hs[p] = 1'($urandom % 2);
                end
            end
            step("R9");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule